// File: doc/BRIEF.md
# Periodic Event Interrupt Unit

This block turns the rollover pulses of a calendar counter into a single interrupt request. Seven pulse inputs mark the end of a second, minute, hour, day, week (the step into Monday), month and year. Software chooses which of these events may interrupt by writing an enable mask into one register on a small byte-wide bus. Each enabled pulse sets a sticky pending flag, and the interrupt line stays high while any flag is set.

Software acknowledges by reading the same register. The read returns the flags as they stood before the read and clears them at the end of that bus cycle. A pulse that arrives in the cycle of the read is not lost: it stays pending and keeps the interrupt line up. Writing the register changes only the mask and leaves the flags alone.

A two-state machine drives the interrupt line. In state QUIET the line is low. The transition RAISE takes it to state RAISED when the next flag value is non-zero. The transition ACK takes it back to QUIET when the next flag value is zero. Otherwise the HOLD transition keeps the current state.

Top module: `evt_irq_unit`

## Requirements
- R1: The register lives at bus address 0x10. A read there returns the pending flags in bits 6:0, with bit 0 for seconds, 1 for minutes, 2 for hours, 3 for days, 4 for weeks, 5 for months and 6 for years. Bit 7 always reads 0. A read at any other address returns 0x00.
- R2: A write at address 0x10 loads bits 6:0 of the write data into the enable mask, using the same bit order as R1. Writes at any other address leave the mask unchanged.
- R3: A one-cycle pulse on rollover input bit k sets pending flag k at the next clock edge when mask bit k is set. When the mask bit is clear, the pulse never sets the flag. Flags are sticky, so pulses in different cycles accumulate.
- R4: irq_o is high exactly when at least one pending flag is set. It rises in the cycle after the enabled pulse.
- R5: A read at 0x10 returns the flags from before the read and clears them at the end of the read cycle. A read at any other address clears nothing.
- R6: An enabled pulse that arrives in the same cycle as a read at 0x10 is absent from that read's data but remains pending afterwards.
- R7: A write leaves the pending flags and irq_o unchanged.
- R8: After reset the mask and all flags are 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| roll_i | input | 7 | Rollover pulses, one bit per event in R1 order |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench drives a pulse in the same cycle as an acknowledging read. A design that cleared after merging the new events would lose that pulse, and a design that returned merged data would report it early. It issues writes while flags are pending, which catches a design that clears on write (the write-one-to-clear habit). It also touches a neighbouring address, where a loose decode would either clear the flags or corrupt the mask. Finally it sets all seven inputs under partial masks, so a swapped bit or a leak from a disabled event shows up in the read data.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int unsigned N_EVT    = 7;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned DATA_W   = 8;
    localparam logic [ADDR_W-1:0] CSR_ADDR = 5'h10;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/evt_csr_decode.sv
module evt_csr_decode #(
    parameter int unsigned ADDR_W = 5,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 5'h10
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic sel;

    always_comb begin
        sel    = (bus_addr == CSR_ADDR);
        wr_hit = sel && bus_wr;
        rd_hit = sel && bus_rd;
    end
endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
    parameter int unsigned N_EVT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] roll_i,
    input  logic [N_EVT-1:0] mask_i,
    input  logic             clr_i,
    output logic [N_EVT-1:0] pend_q,
    output logic [N_EVT-1:0] pend_nxt
);
    for (genvar k = 0; k < N_EVT; k++) begin : g_flag
        logic hit;
        always_comb begin
            hit         = roll_i[k] && mask_i[k];
            pend_nxt[k] = hit || (pend_q[k] && !clr_i);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[k] <= 1'b0;
            else        pend_q[k] <= pend_nxt[k];
        end
    end
endmodule

// File: rtl/evt_irq_fsm.sv
module evt_irq_fsm
    import evt_irq_pkg::*;
#(
    parameter int unsigned N_EVT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] pend_nxt,
    output logic             irq_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (|pend_nxt)  state_d = ST_RAISED; // RAISE
            ST_RAISED: if (!(|pend_nxt)) state_d = ST_QUIET; // ACK
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RAISED: irq_o = 1'b1;
            default:   irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int unsigned EVTS  = N_EVT,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned DW    = DATA_W,
    parameter logic [AW-1:0] REG_ADDR = CSR_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EVTS-1:0] roll_i,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);
    localparam int unsigned PAD_W = DW - EVTS;

    logic            wr_hit, rd_hit;
    logic [EVTS-1:0] mask_q;
    logic [EVTS-1:0] pend_q, pend_nxt;

    evt_csr_decode #(.ADDR_W(AW), .CSR_ADDR(REG_ADDR)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= '0;
        else if (wr_hit) mask_q <= bus_wdata[EVTS-1:0];
    end

    evt_pend_bank #(.N_EVT(EVTS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .roll_i   (roll_i),
        .mask_i   (mask_q),
        .clr_i    (rd_hit),
        .pend_q   (pend_q),
        .pend_nxt (pend_nxt)
    );

    evt_irq_fsm #(.N_EVT(EVTS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (pend_nxt),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) bus_rdata = {{PAD_W{1'b0}}, pend_q};
    end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
    parameter int unsigned EVTS = 7,
    parameter int unsigned AW   = 5,
    parameter int unsigned DW   = 8,
    parameter logic [AW-1:0] REG_ADDR = 5'h10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [EVTS-1:0] roll_i,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [DW-1:0]   bus_rdata,
    input logic            irq_o,
    input logic [EVTS-1:0] mask_q,
    input logic [EVTS-1:0] pend_q
);
    logic rd_sel, wr_sel;
    assign rd_sel = bus_rd && (bus_addr == REG_ADDR);
    assign wr_sel = bus_wr && (bus_addr == REG_ADDR);

    always_comb begin
        if (rst_n) begin
            AST_TOP_BIT_ZERO: assert (bus_rdata[DW-1] == 1'b0); // R1
        end
    end

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(mask_q)); // R2

    AST_NO_UNENABLED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(roll_i & mask_q)) == '0)); // R3

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pend_q != '0)); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |=> ((pend_q & ~$past(roll_i & mask_q)) == '0)); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |=> (($past(pend_q) & ~pend_q) == '0)); // R7
endmodule

bind evt_irq_unit evt_irq_chk #(.EVTS(EVTS), .AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .roll_i    (roll_i),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .pend_q    (pend_q)
);

// File: tb/tb_evt_irq_unit.sv
module tb_evt_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] roll_i = '0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    evt_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .roll_i(roll_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // {mask, roll, expected pending}
    localparam logic [20:0] VEC [0:7] = '{
        {7'h7F, 7'h01, 7'h01},
        {7'h7F, 7'h40, 7'h40},
        {7'h00, 7'h7F, 7'h00},
        {7'h55, 7'h7F, 7'h55},
        {7'h2A, 7'h7F, 7'h2A},
        {7'h0F, 7'h30, 7'h00},
        {7'h70, 7'h31, 7'h30},
        {7'h7F, 7'h7F, 7'h7F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] r);
        @(negedge clk); roll_i = r;
        @(negedge clk); roll_i = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        check("R8 irq after reset", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;
        bus_read(5'h10, d);
        check("R8 pending after reset", d, 8'h00);
        pulse(7'h7F);
        check("R8 mask cleared by reset", {7'd0, irq_o}, 8'h00);

        for (int i = 0; i < 8; i++) begin
            bus_write(5'h10, {1'b1, VEC[i][20:14]});
            pulse(VEC[i][13:7]);
            check("R4 irq follows pending", {7'd0, irq_o}, {7'd0, |VEC[i][6:0]});
            bus_read(5'h10, d);
            check("R3 R1 pending bits", d, {1'b0, VEC[i][6:0]});
            check("R5 irq low after ack", {7'd0, irq_o}, 8'h00);
        end

        // R3 accumulation across cycles
        bus_write(5'h10, 8'h7F);
        pulse(7'h02); pulse(7'h08);
        bus_read(5'h10, d);
        check("R3 accumulate", d, 8'h0A);
        bus_read(5'h10, d);
        check("R5 second read empty", d, 8'h00);

        // R6 event during read stays pending
        pulse(7'h01);
        @(negedge clk); bus_addr = 5'h10; bus_rd = 1'b1; roll_i = 7'h04;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; roll_i = '0;
        check("R6 read excludes same-cycle event", d, 8'h01);
        check("R6 irq kept", {7'd0, irq_o}, 8'h01);
        bus_read(5'h10, d);
        check("R6 event still pending", d, 8'h04);

        // R7 write leaves pending
        pulse(7'h20);
        bus_write(5'h10, 8'h00);
        check("R7 irq after write", {7'd0, irq_o}, 8'h01);
        bus_read(5'h10, d);
        check("R7 pending after write", d, 8'h20);

        // R2 write elsewhere ignored; R1 R5 read elsewhere
        bus_write(5'h10, 8'h10);
        bus_write(5'h11, 8'h00);
        pulse(7'h10);
        bus_read(5'h11, d);
        check("R1 other address reads zero", d, 8'h00);
        check("R5 other read keeps irq", {7'd0, irq_o}, 8'h01);
        bus_read(5'h10, d);
        check("R2 mask kept after stray write", d, 8'h10);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule